// File: doc/BRIEF.md
# Width-Converting DMA Burst FIFO

This block is the staging buffer that holds burst data between the read phase and the write phase of a DMA transfer. It stores sixteen 32-bit entries. Data enters in units of the source width and leaves in units of the destination width, and the two widths are chosen independently for each access. Narrow units are packed into entries and wide entries are split into narrow units. Packing is little-endian: the oldest byte sits in the least significant lane. One buffer is shared by every DMA stream, but it serves only one burst at a time. A flush clears it whenever the arbiter changes streams or a transfer ends.

Occupancy is counted in bytes. A write is taken only when there is free space for the whole source unit. A read is taken only when a whole destination unit is stored. The read port is show-ahead: the unit at the head of the buffer is always on `rd_data`, and `rd_en` consumes it. Arbitration, address generation and bus protocol are handled outside this block.

Top module: `dma_pack_fifo`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, `rd_valid` is 0 and `wr_ready` is 1.
- R2: Width code 0 means a byte (1 byte), code 1 a half-word (2 bytes), and codes 2 and 3 a word (4 bytes). This holds on both ports. An accepted write raises the level by the source unit size.
- R3: Packing is little-endian. Bytes written one after another fill bits 7:0, 15:8, 23:16 and 31:24 of a later word read, oldest byte in the lowest lane. A half-word goes to bits 15:0 first.
- R4: Unpacking keeps the order. A word that is written and then read as bytes gives its bits 7:0 first, then 15:8, 23:16 and 31:24.
- R5: `rd_data` carries the head unit in its low bits, and every bit above the destination unit size is 0.
- R6: `wr_ready` is 1 exactly when the level plus the source unit size is no more than 64. A write while `wr_ready` is 0 changes neither the level nor the stored data.
- R7: `rd_valid` is 1 exactly when the level is at least the destination unit size. A read while `rd_valid` is 0 changes neither the level nor the head data.
- R8: When a write and a read are both accepted in the same cycle, the next level is the old level plus the bytes written minus the bytes read. Acceptance in that cycle is judged on the old level.
- R9: `flush` sets the level to 0 at the next edge and drops any partial data. A write or read in the same cycle is ignored. Data written after a flush is read back first.
- R10: `full` is 1 exactly when the level is 64. `empty` is 1 exactly when the level is 0.
- R11: Sixteen word writes into an empty buffer are all accepted and fill it to 64 bytes.
- R12: Byte order is kept when the pointers wrap past the end of the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard contents and reset pointers |
| wr_en | input | 1 | Write request |
| wr_width | input | 2 | Source unit width code |
| wr_data | input | 32 | Write data, unit in the low bits |
| wr_ready | output | 1 | A write of the current width would be accepted |
| rd_en | input | 1 | Read request (consumes the head unit) |
| rd_width | input | 2 | Destination unit width code |
| rd_data | output | 32 | Head unit, zero-extended |
| rd_valid | output | 1 | A read of the current width would be accepted |
| level | output | 7 | Stored bytes, 0 to 64 |
| full | output | 1 | Level equals 64 |
| empty | output | 1 | Level equals 0 |

## Verification
A wrong read or write pointer shows up as wrong byte order or stale bytes on `rd_data` at the next read after the fault. Wrong byte order is most visible when the widths on the two ports differ or when the pointers wrap. A wrong level is seen on `level` in the same cycle. A few cycles later it shows as `wr_ready` or `rd_valid` disagreeing with the byte count the bench tracks, before any data is lost. A flush that fails to clear the buffer shows on the very next edge as a nonzero level. The stimulus mixes widths at random on both ports and adds occasional flushes, so each of these faults is reached within a few hundred cycles.

// File: rtl/dma_pkfifo_pkg.sv
package dma_pkfifo_pkg;

   // Unit width encoding shared by both ports
   typedef enum logic [1:0] {
      UW_BYTE = 2'd0,
      UW_HALF = 2'd1,
      UW_WORD = 2'd2,
      UW_WIDE = 2'd3
   } unit_w_e;

   localparam int UNIT_MAX = 4;

   function automatic logic [2:0] unit_bytes(input logic [1:0] code);
      case (unit_w_e'(code))
         UW_BYTE: return 3'd1;
         UW_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dma_pkfifo_ctrl.sv
module dma_pkfifo_ctrl #(
   parameter int DEPTH_B = 64,
   parameter int PTR_W   = $clog2(DEPTH_B),
   parameter int LVL_W   = $clog2(DEPTH_B + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [2:0]       wr_bytes,
   input  logic             rd_en,
   input  logic [2:0]       rd_bytes,
   output logic             wr_fire,
   output logic             rd_fire,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [LVL_W-1:0] level,
   output logic             wr_ready,
   output logic             rd_valid
);

   localparam logic [LVL_W:0] CAP = (LVL_W+1)'(DEPTH_B);

   logic [LVL_W:0] after_wr;

   assign after_wr = {1'b0, level} + (LVL_W+1)'(wr_bytes);
   assign wr_ready = (after_wr <= CAP);
   assign rd_valid = ({1'b0, level} >= (LVL_W+1)'(rd_bytes));
   assign wr_fire  = wr_en && wr_ready && !flush;
   assign rd_fire  = rd_en && rd_valid && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (wr_fire) wr_ptr <= wr_ptr + PTR_W'(wr_bytes);
         if (rd_fire) rd_ptr <= rd_ptr + PTR_W'(rd_bytes);
         level <= level + (wr_fire ? LVL_W'(wr_bytes) : '0)
                        - (rd_fire ? LVL_W'(rd_bytes) : '0);
      end
   end

endmodule

// File: rtl/dma_pkfifo_store.sv
module dma_pkfifo_store #(
   parameter int DEPTH_B = 64,
   parameter int PTR_W   = $clog2(DEPTH_B),
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              wr_fire,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [2:0]        wr_bytes,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic [2:0]        rd_bytes,
   output logic [DATA_W-1:0] rd_data
);
   import dma_pkfifo_pkg::*;

   localparam int LANES = DATA_W / 8;

   logic [7:0] mem [DEPTH_B];

   // Byte-addressed storage: unit lanes land at consecutive byte slots
   always_ff @(posedge clk) begin
      for (int i = 0; i < UNIT_MAX; i++) begin
         if (wr_fire && (3'(i) < wr_bytes))
            mem[PTR_W'(wr_ptr + PTR_W'(i))] <= wr_data[8*i +: 8];
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l < UNIT_MAX) begin : g_unit
         assign rd_data[8*l +: 8] = (3'(l) < rd_bytes)
                                  ? mem[PTR_W'(rd_ptr + PTR_W'(l))] : 8'h00;
      end else begin : g_pad
         assign rd_data[8*l +: 8] = 8'h00;
      end
   end

endmodule

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo #(
   parameter int ENTRIES = 16,
   parameter int DATA_W  = 32,
   localparam int LANES   = DATA_W / 8,
   localparam int DEPTH_B = ENTRIES * LANES,
   localparam int PTR_W   = $clog2(DEPTH_B),
   localparam int LVL_W   = $clog2(DEPTH_B + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [1:0]        wr_width,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              rd_en,
   input  logic [1:0]        rd_width,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty
);
   import dma_pkfifo_pkg::*;

   if (DATA_W % 8 != 0 || DATA_W < 8 * UNIT_MAX)
      $error("dma_pack_fifo: DATA_W must be a byte multiple of at least 32");
   if ((ENTRIES & (ENTRIES - 1)) != 0 || (LANES & (LANES - 1)) != 0)
      $error("dma_pack_fifo: ENTRIES and lane count must be powers of two");

   logic [2:0]       wr_bytes, rd_bytes;
   logic             wr_fire, rd_fire;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   assign wr_bytes = unit_bytes(wr_width);
   assign rd_bytes = unit_bytes(rd_width);

   dma_pkfifo_ctrl #(.DEPTH_B(DEPTH_B), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (wr_en),
      .wr_bytes (wr_bytes),
      .rd_en    (rd_en),
      .rd_bytes (rd_bytes),
      .wr_fire  (wr_fire),
      .rd_fire  (rd_fire),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .level    (level),
      .wr_ready (wr_ready),
      .rd_valid (rd_valid)
   );

   dma_pkfifo_store #(.DEPTH_B(DEPTH_B), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .wr_fire  (wr_fire),
      .wr_ptr   (wr_ptr),
      .wr_bytes (wr_bytes),
      .wr_data  (wr_data),
      .rd_ptr   (rd_ptr),
      .rd_bytes (rd_bytes),
      .rd_data  (rd_data)
   );

   assign full  = (level == LVL_W'(DEPTH_B));
   assign empty = (level == '0);

endmodule

// File: rtl/dma_pack_fifo_chk.sv
module dma_pack_fifo_chk #(
   parameter int DEPTH_B = 64,
   parameter int LVL_W   = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             wr_en,
   input logic [1:0]       wr_width,
   input logic             rd_en,
   input logic [1:0]       rd_width,
   input logic             wr_ready,
   input logic             rd_valid,
   input logic [LVL_W-1:0] level,
   input logic             full,
   input logic             empty
);
   import dma_pkfifo_pkg::*;

   logic [LVL_W+1:0] pred;
   logic             pred_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_ok <= 1'b0;
         pred    <= '0;
      end else begin
         pred_ok <= !flush;
         pred    <= (LVL_W+2)'(level)
                  + ((wr_en && wr_ready) ? (LVL_W+2)'(unit_bytes(wr_width)) : '0)
                  - ((rd_en && rd_valid) ? (LVL_W+2)'(unit_bytes(rd_width)) : '0);
      end
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (LVL_W+1)'(level) <= (LVL_W+1)'(DEPTH_B));

   // R6
   full_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !wr_ready);

   // R7
   empty_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !rd_valid);

   // R9
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

   // R8
   level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_ok |-> ((LVL_W+2)'(level) == pred));

endmodule

bind dma_pack_fifo dma_pack_fifo_chk #(.DEPTH_B(DEPTH_B), .LVL_W(LVL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flush    (flush),
   .wr_en    (wr_en),
   .wr_width (wr_width),
   .rd_en    (rd_en),
   .rd_width (rd_width),
   .wr_ready (wr_ready),
   .rd_valid (rd_valid),
   .level    (level),
   .full     (full),
   .empty    (empty)
);

// File: tb/test_dma_pack_fifo.sv
`timescale 1ns/1ps
module test_dma_pack_fifo;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_width = 2'd0;
   logic [31:0] wr_data = '0;
   logic        wr_ready;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_width = 2'd0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic [6:0]  level;
   logic        full, empty;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] q[$];

   always #4 clk = ~clk;

   dma_pack_fifo i_dma_pack_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(wr_en), .wr_width(wr_width), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_en(rd_en), .rd_width(rd_width), .rd_data(rd_data), .rd_valid(rd_valid),
      .level(level), .full(full), .empty(empty)
   );

   function automatic int ubytes(input logic [1:0] c);
      return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] head_unit(input int nb);
      logic [31:0] v = '0;
      for (int i = 0; i < nb; i++) v[8*i +: 8] = q[i];
      return v;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   // One cycle: drive at the falling edge, check combinational outputs, clock, update model
   task automatic cyc(input bit fl, input bit we, input logic [1:0] ww,
                      input logic [31:0] wd, input bit re, input logic [1:0] rw,
                      input string tag);
      int  wb = ubytes(ww);
      int  rb = ubytes(rw);
      bit  ewr, erd;
      flush = fl; wr_en = we; wr_width = ww; wr_data = wd; rd_en = re; rd_width = rw;
      #1;
      ewr = (q.size() + wb) <= 64;
      erd = q.size() >= rb;
      chk("R2 R8", "level", 32'(level), 32'(q.size()));
      chk("R6", "wr_ready", 32'(wr_ready), 32'(ewr));
      chk("R7", "rd_valid", 32'(rd_valid), 32'(erd));
      chk("R10", "full", 32'(full), 32'(q.size() == 64));
      chk("R10", "empty", 32'(empty), 32'(q.size() == 0));
      if (erd) chk(tag, "rd_data", rd_data, head_unit(rb));
      @(posedge clk);
      if (fl) q.delete();
      else begin
         if (re && erd) for (int i = 0; i < rb; i++) void'(q.pop_front());
         if (we && ewr) for (int i = 0; i < wb; i++) q.push_back(wd[8*i +: 8]);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "level", 32'(level), 0);
      chk("R1", "empty", 32'(empty), 1);
      chk("R1", "full", 32'(full), 0);
      chk("R1", "rd_valid", 32'(rd_valid), 0);
      chk("R1", "wr_ready", 32'(wr_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 byte packing into a word
      cyc(0, 1, 2'd0, 32'hFFFF_FF11, 0, 2'd2, "R3");
      cyc(0, 1, 2'd0, 32'hEEEE_EE22, 0, 2'd2, "R3");
      cyc(0, 1, 2'd0, 32'hDDDD_DD33, 0, 2'd2, "R3");
      cyc(0, 1, 2'd0, 32'hCCCC_CC44, 0, 2'd2, "R3");
      chk("R3", "packed word", rd_data, 32'h4433_2211);
      cyc(0, 0, 2'd0, 32'h0, 1, 2'd2, "R3");
      // R3 half-word packing
      cyc(0, 1, 2'd1, 32'h9999_BEEF, 0, 2'd2, "R3");
      cyc(0, 1, 2'd1, 32'h8888_CAFE, 0, 2'd2, "R3");
      cyc(0, 0, 2'd0, 32'h0, 1, 2'd3, "R3");
      // R4 word unpacked to bytes, R5 upper bits zero
      cyc(0, 1, 2'd2, 32'hAABB_CCDD, 0, 2'd0, "R4");
      chk("R5", "byte zero-extend", rd_data, 32'h0000_00DD);
      for (int i = 0; i < 4; i++) cyc(0, 0, 2'd0, 32'h0, 1, 2'd0, "R4");
      // R11 fill with sixteen words
      for (int i = 0; i < 16; i++) cyc(0, 1, 2'd2, 32'h1000_0000 + 32'(i), 0, 2'd1, "R5");
      chk("R11", "level full", 32'(level), 64);
      // R6 write refused when full
      cyc(0, 1, 2'd0, 32'h0000_00EE, 0, 2'd1, "R6");
      chk("R6", "level after refused write", 32'(level), 64);
      // R8 simultaneous: read half, write refused (old level full)
      cyc(0, 1, 2'd1, 32'h0000_7777, 1, 2'd1, "R8");
      cyc(0, 1, 2'd1, 32'h0000_6666, 1, 2'd0, "R8");
      // R9 flush with simultaneous write
      cyc(1, 1, 2'd2, 32'hDEAD_BEEF, 1, 2'd0, "R9");
      chk("R9", "level after flush", 32'(level), 0);
      // R7 read refused when empty
      cyc(0, 0, 2'd0, 32'h0, 1, 2'd0, "R7");
      chk("R7", "level after refused read", 32'(level), 0);
      // R9 partial data dropped
      cyc(0, 1, 2'd0, 32'h0000_0055, 0, 2'd2, "R9");
      cyc(0, 1, 2'd0, 32'h0000_0066, 0, 2'd2, "R9");
      cyc(1, 0, 2'd0, 32'h0, 0, 2'd2, "R9");
      cyc(0, 1, 2'd2, 32'h0102_0304, 0, 2'd2, "R9");
      chk("R9", "fresh data after flush", rd_data, 32'h0102_0304);
      cyc(0, 0, 2'd0, 32'h0, 1, 2'd2, "R9");

      // R12 R8 random mixed widths, wrapping pointers, rare flushes
      for (int n = 0; n < 4000; n++) begin
         bit fl = ($urandom % 60) == 0;
         bit we = ($urandom % 100) < 55;
         bit re = ($urandom % 100) < 50;
         cyc(fl, we, 2'($urandom), $urandom, re, 2'($urandom), "R12");
      end

      summary();
      $finish;
   end

endmodule